// File: doc/BRIEF.md
# Single-Level Interrupt Controller

This block collects interrupt requests from up to eight devices into a pending register and forwards one level-sensitive request upstream. Devices post and withdraw requests with bit-vector set and clear inputs that are sampled every clock. Software reaches the block through a small byte-wide register port. It programs an 8-bit mask in which a 1 disables a source, and it reads the mask back and reads the pending bits. To retire a request it writes the number of the source to an acknowledge register.

A second controller is decoded in the same register space only as a stub. It can store and return a mask byte. Its status always reads zero. Writes to its acknowledge register do nothing. There is no priority logic, no vector generation and no trigger-mode programming. The upstream request is simply high while any pending source is enabled.

All state sits in registers. A write, set or clear applied before a rising edge is visible at the read port and at the request output after that edge.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset the pending register is 0x00, every source is disabled (mask reads 0xFF), the secondary mask reads 0x00 and `irqOut` is low.
- R2: A write to address 0 (primary mask, 1 = source disabled) stores the inverse of the byte as the enable mask. A read of address 0 returns the byte last written.
- R3: From the edge that registers a change to pending or mask state, `irqOut` is high exactly when (pending AND enable) is nonzero.
- R4: Each bit set in `srcSet` sets the matching pending bit. Other pending bits are left unchanged.
- R5: Each bit set in `srcClr` clears the matching pending bit. Other pending bits are left unchanged.
- R6: A write to address 2 (acknowledge) clears the pending bit whose index is bits 3:0 of the byte. Bits 7:4 are ignored, and an index of 8 to 15 clears nothing.
- R7: When a set, a clear and an acknowledge fall in the same cycle, they take effect in that order: set, then clear, then acknowledge. `irqOut` follows the final pending value.
- R8: A read of address 1 (status) returns the pending register.
- R9: Address 3 (secondary mask) stores the written byte and reads it back unchanged. Address 4 (secondary status) always reads 0x00. A write to address 5 (secondary acknowledge) changes no state.
- R10: Addresses 6 and 7 read as 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address for reads and writes |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| srcSet | input | 8 | Per-source request set vector |
| srcClr | input | 8 | Per-source request clear vector |
| irqOut | output | 1 | Level request to the upstream interrupt handler |

## Verification
The bench builds the block with its default eight sources and a four-bit acknowledge index. At this size every mask byte can be swept against a fixed pending pattern, and every one of the sixteen acknowledge indices can be tried with several upper-nibble values. A grid of set and clear patterns is also driven in the same cycle as an acknowledge, so the set-clear-acknowledge ordering is exercised on many bit overlaps. The expected pending value and request level are recomputed in the bench after every step.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int ACK_IDX_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_MASK    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ACK     = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK2   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS2 = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_ACK2    = 3'd5;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASK,
    RD_STATUS,
    RD_MASK2,
    RD_ZERO
  } rdSelE;

  typedef struct packed {
    logic                 maskWr;
    logic                 ackWr;
    logic                 mask2Wr;
    logic [ACK_IDX_W-1:0] ackIdx;
    logic [DATA_W-1:0]    wrData;
    rdSelE                rdSel;
  } ctlStrobesT;

endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
  import irq_ctl_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ctlStrobesT        strobes
);

  always_comb begin
    strobes         = '0;
    strobes.wrData  = busWrData;
    strobes.ackIdx  = busWrData[ACK_IDX_W-1:0];
    strobes.rdSel   = RD_ZERO;
    unique case (busAddr)
      ADDR_MASK: begin
        strobes.maskWr = busWrEn;
        strobes.rdSel  = RD_MASK;
      end
      ADDR_STATUS: strobes.rdSel = RD_STATUS;
      ADDR_ACK:    strobes.ackWr = busWrEn;
      ADDR_MASK2: begin
        strobes.mask2Wr = busWrEn;
        strobes.rdSel   = RD_MASK2;
      end
      ADDR_STATUS2: strobes.rdSel = RD_ZERO;
      ADDR_ACK2:    strobes.rdSel = RD_ZERO;
      default:      strobes.rdSel = RD_ZERO;
    endcase
  end

  always_comb begin
    assert_one_write_strobe_R10: assert ($countones({strobes.maskWr, strobes.ackWr, strobes.mask2Wr}) <= 1);
  end

endmodule

// File: rtl/irq_ctl_datapath.sv
module irq_ctl_datapath
  import irq_ctl_pkg::*;
#(
  parameter int SRC_COUNT = DATA_W,
  parameter int IDX_W     = ACK_IDX_W
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobesT           strobes,
  input  logic [SRC_COUNT-1:0] srcSet,
  input  logic [SRC_COUNT-1:0] srcClr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut
);

  logic [SRC_COUNT-1:0] pending, pendNext;
  logic [SRC_COUNT-1:0] enable, enNext;
  logic [DATA_W-1:0]    mask2;
  logic [SRC_COUNT-1:0] ackVec;
  logic [SRC_COUNT-1:0] afterSet, afterClr;
  logic                 irqQ;

  // one decoded acknowledge bit per source; indices past the last source match nothing
  for (genvar i = 0; i < SRC_COUNT; i++) begin : gAck
    assign ackVec[i] = strobes.ackWr && (strobes.ackIdx == IDX_W'(i));
  end

  always_comb begin
    afterSet = pending | srcSet;
    afterClr = afterSet & ~srcClr;
    pendNext = afterClr & ~ackVec;
    enNext   = strobes.maskWr ? ~strobes.wrData[SRC_COUNT-1:0] : enable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      enable  <= '0;
      mask2   <= '0;
      irqQ    <= 1'b0;
    end else begin
      pending <= pendNext;
      enable  <= enNext;
      if (strobes.mask2Wr) mask2 <= strobes.wrData;
      irqQ    <= |(pendNext & enNext);
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_MASK:   rdData = DATA_W'(~enable);
      RD_STATUS: rdData = DATA_W'(pending);
      RD_MASK2:  rdData = mask2;
      default:   rdData = '0;
    endcase
  end

  assign irqOut = irqQ;

  assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(pending & enable));

  assert_mask_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWr |=> enable == ~$past(strobes.wrData[SRC_COUNT-1:0]));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pending & $past(srcClr)) == '0);

  assert_set_sticks_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pending & $past(srcSet & ~srcClr & ~ackVec)) == $past(srcSet & ~srcClr & ~ackVec));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackWr && strobes.ackIdx < IDX_W'(SRC_COUNT)) |=>
      ((pending >> $past(strobes.ackIdx)) & SRC_COUNT'(1)) == '0);

  assert_ack_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackWr && strobes.ackIdx >= IDX_W'(SRC_COUNT) && srcClr == '0) |=>
      (pending & $past(pending)) == $past(pending));

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(!rstN) && rstN |-> pending == '0 && enable == '0 && !irqOut);

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [2:0]        busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [7:0]        srcSet,
  input  logic [7:0]        srcClr,
  output logic              irqOut
);

  ctlStrobesT strobes;

  irq_ctl_decode uDecode (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strobes  (strobes)
  );

  irq_ctl_datapath #(
    .SRC_COUNT(DATA_W),
    .IDX_W    (ACK_IDX_W)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .srcSet (srcSet),
    .srcClr (srcClr),
    .rdData (busRdData),
    .irqOut (irqOut)
  );

  assert_stub_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_STATUS2) |-> busRdData == 8'h00);

endmodule

// File: tb/tb_irq_ctl_top.sv
`timescale 1ns/1ps
module tb_irq_ctl_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] srcSet = '0;
  logic [7:0] srcClr = '0;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] pendM, enM, mask2M;
  logic       finished = 1'b0;

  always #10 clk = ~clk;

  irq_ctl_top dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .srcSet(srcSet), .srcClr(srcClr), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle of stimulus: drive after a falling edge, release at the next falling edge
  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic [7:0] s, input logic [7:0] c);
    logic [7:0] ackBit;
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; srcSet = s; srcClr = c;
    @(negedge clk);
    busWrEn = 1'b0; srcSet = '0; srcClr = '0;
    ackBit = (we && a == 3'd2 && d[3:0] < 4'd8) ? (8'd1 << d[3:0]) : 8'd0;
    pendM = ((pendM | s) & ~c) & ~ackBit;
    if (we && a == 3'd0) enM = ~d;
    if (we && a == 3'd3) mask2M = d;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic checkIrq(input string req);
    check(req, {7'd0, irqOut}, {7'd0, |(pendM & enM)});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    pendM = 0; enM = 0; mask2M = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(3'd0, v); check("R1 mask", v, 8'hFF);
    readReg(3'd1, v); check("R1 pending", v, 8'h00);
    readReg(3'd3, v); check("R1 mask2", v, 8'h00);
    check("R1 irq", {7'd0, irqOut}, 8'h00);

    // R4 set while disabled; R3 irq stays low
    step(1'b0, 3'd0, 8'h00, 8'hA5, 8'h00);
    readReg(3'd1, v); check("R4 set", v, pendM);
    checkIrq("R3 disabled");

    // R2/R3 full mask sweep against pending 0xA5
    for (int m = 0; m < 256; m++) begin
      step(1'b1, 3'd0, 8'(m), 8'h00, 8'h00);
      readReg(3'd0, v); check("R2 mask readback", v, 8'(m));
      checkIrq("R3 mask sweep");
    end

    // R5 clear patterns with all sources enabled
    step(1'b1, 3'd0, 8'h00, 8'h00, 8'h00);
    for (int c = 0; c < 256; c += 37) begin
      step(1'b0, 3'd0, 8'h00, 8'hFF, 8'h00);
      step(1'b0, 3'd0, 8'h00, 8'h00, 8'(c));
      readReg(3'd1, v); check("R5 clear", v, pendM);
      checkIrq("R3 after clear");
    end

    // R6 acknowledge every index with several upper nibbles
    for (int hi = 0; hi < 16; hi += 5) begin
      for (int idx = 0; idx < 16; idx++) begin
        step(1'b0, 3'd0, 8'h00, 8'hFF, 8'h00);
        step(1'b1, 3'd2, 8'((hi << 4) | idx), 8'h00, 8'h00);
        readReg(3'd1, v); check("R6 ack", v, pendM);
        checkIrq("R3 after ack");
      end
    end

    // R3 drop to low through acknowledge of the last enabled bit
    step(1'b0, 3'd0, 8'h00, 8'h00, 8'hFF);
    step(1'b0, 3'd0, 8'h00, 8'h10, 8'h00);
    checkIrq("R3 single pending");
    step(1'b1, 3'd2, 8'h04, 8'h00, 8'h00);
    check("R3 ack drops irq", {7'd0, irqOut}, 8'h00);

    // R7 set, clear and acknowledge in one cycle
    step(1'b1, 3'd0, 8'h0F, 8'h00, 8'h00);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        step(1'b0, 3'd0, 8'h00, 8'(i * 13), 8'h00);
        step(1'b1, 3'd2, 8'((i + j) % 16), 8'(i * 17), 8'(j * 11));
        readReg(3'd1, v); check("R7 ordering", v, pendM);
        checkIrq("R7 irq");
      end
    end

    // R8 status readback of a distinctive pattern
    step(1'b0, 3'd0, 8'h00, 8'h00, 8'hFF);
    step(1'b0, 3'd0, 8'h00, 8'h3C, 8'h00);
    readReg(3'd1, v); check("R8 status", v, 8'h3C);

    // R9 secondary stub
    step(1'b1, 3'd3, 8'h5A, 8'h00, 8'h00);
    readReg(3'd3, v); check("R9 mask2", v, 8'h5A);
    readReg(3'd4, v); check("R9 status2", v, 8'h00);
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 3'd5, 8'(k), 8'h00, 8'h00);
      readReg(3'd1, v); check("R9 ack2 no effect", v, 8'h3C);
    end
    readReg(3'd0, v); check("R9 mask untouched", v, ~enM);

    // R10 unmapped addresses
    for (int a = 6; a < 8; a++) begin
      step(1'b1, 3'(a), 8'h02, 8'h00, 8'h00);
      readReg(3'(a), v); check("R10 unmapped read", v, 8'h00);
      readReg(3'd1, v); check("R10 pending kept", v, 8'h3C);
      readReg(3'd0, v); check("R10 mask kept", v, ~enM);
      readReg(3'd3, v); check("R10 mask2 kept", v, 8'h5A);
    end
    checkIrq("R3 final");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule